// File: doc/BRIEF.md
# Stack and Status-Flag Execution Unit

This unit carries out the stack and flag-manipulation instructions of a small 8-bit accumulator processor. A decoder outside the block hands it a 4-bit operation code together with a one-cycle start strobe. The unit owns the accumulator, the 8-bit stack pointer and the 8-bit status register. It performs its own stack traffic through a simple synchronous memory port, whose read data arrives one cycle after the read enable. It raises `done` for one cycle in the final cycle of each operation.

Single-flag set and clear operations change one status bit. Pushes store either the accumulator or the status byte. Pulls restore either of them. The return-from-interrupt operation restores the status byte and then a 16-bit return address, which it presents on `ret_pc`. Bits 5 and 4 of the status byte are treated in a particular way when it moves to or from the stack. Each class of operation takes its own fixed number of cycles.

Top module: `stk_flag_exec`

## Requirements
- R1: Every stack access drives `mem_addr` as {STACK_PAGE, stack pointer}, which is 0x0100 plus the pointer with the default page of 1.
- R2: A push writes at the current pointer and then decrements it. A pull first increments the pointer and then reads at the new value. Both directions wrap modulo 256. `mem_we` and `mem_re` are never high together.
- R3: PHP (code 10) writes the status register with bit 5 and bit 4 forced to 1. PHA (code 8) writes the accumulator.
- R4: PLP (code 11) and RTI (code 12) load the pulled status byte with bits 5 and 4 cleared to 0.
- R5: PLA (code 9) loads the accumulator from the stack. It sets status bit 7 to bit 7 of the value and status bit 1 to 1 exactly when the value is zero. All other status bits are left unchanged.
- R6: RTI pulls in this order: the status byte, the return address low byte, the return address high byte. It then presents {high, low} on `ret_pc`. The pointer ends 3 above its start.
- R7: Flag codes use the status layout N=7, V=6, D=3, I=2, C=0. The codes are CLC=1, SEC=2, CLI=3, SEI=4, CLV=5, CLD=6, SED=7. Each changes only its own bit.
- R8: Counting the cycle after the start edge as cycle 1, `done` is high in cycle N. N is 1 for NOP (code 0) and the flag codes, 2 for pushes, 3 for PLA and PLP, and 6 for RTI. While idle, `done`, `mem_we` and `mem_re` stay low.
- R9: `done` is high for exactly one cycle per operation. A start seen while `busy` is high, including the `done` cycle, is ignored.
- R10: After reset the stack pointer is 0xFF, the accumulator is 0x00, the status register is 0x24 and `ret_pc` is 0x0000.
- R11: The unused codes 13 to 15 act as NOP: they take one cycle and change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Start strobe, sampled while idle |
| op_code | input | 4 | Operation code |
| mem_addr | output | 16 | Stack memory address |
| mem_wdata | output | 8 | Stack write data |
| mem_rdata | input | 8 | Stack read data, valid the cycle after `mem_re` |
| mem_we | output | 1 | Stack write enable |
| mem_re | output | 1 | Stack read enable |
| busy | output | 1 | Operation in progress |
| done | output | 1 | Final-cycle pulse |
| acc_q | output | 8 | Accumulator |
| sp_q | output | 8 | Stack pointer |
| status_q | output | 8 | Status register |
| ret_pc | output | 16 | Return address restored by RTI |

## Verification
PLA runs on all 256 byte values, and each one is pushed back with PHA. This exhaustive sweep separates the zero and negative flag rules from data corruption. PLP is swept over all 256 values, each followed by PHP, which shows that bits 5 and 4 are cleared on the way in and forced on the way out while the other six bits pass through. RTI is run from a pointer of 0xFF, so its three pulls cross the wrap. Its address bytes are chosen distinct so that a swapped pull order shows on `ret_pc`. A start held high across a whole pull checks that a request made while busy is dropped.

// File: rtl/stk_flag_pkg.sv
package stk_flag_pkg;
   localparam int STEP_W = 3;

   localparam logic [3:0] OPC_NOP = 4'd0;
   localparam logic [3:0] OPC_CLC = 4'd1;
   localparam logic [3:0] OPC_SEC = 4'd2;
   localparam logic [3:0] OPC_CLI = 4'd3;
   localparam logic [3:0] OPC_SEI = 4'd4;
   localparam logic [3:0] OPC_CLV = 4'd5;
   localparam logic [3:0] OPC_CLD = 4'd6;
   localparam logic [3:0] OPC_SED = 4'd7;
   localparam logic [3:0] OPC_PHA = 4'd8;
   localparam logic [3:0] OPC_PLA = 4'd9;
   localparam logic [3:0] OPC_PHP = 4'd10;
   localparam logic [3:0] OPC_PLP = 4'd11;
   localparam logic [3:0] OPC_RTI = 4'd12;

   localparam int FL_C = 0;
   localparam int FL_Z = 1;
   localparam int FL_I = 2;
   localparam int FL_D = 3;
   localparam int FL_B = 4;
   localparam int FL_U = 5;
   localparam int FL_V = 6;
   localparam int FL_N = 7;

   // bits forced on push of status and cleared on pull of status
   localparam logic [7:0] STK_SPECIAL = 8'h30;

   // index of the final step of each operation (cycle count minus one)
   function automatic logic [STEP_W-1:0] last_step(input logic [3:0] op);
      case (op)
         OPC_PHA, OPC_PHP: last_step = STEP_W'(1);
         OPC_PLA, OPC_PLP: last_step = STEP_W'(2);
         OPC_RTI:          last_step = STEP_W'(5);
         default:          last_step = STEP_W'(0);
      endcase
   endfunction
endpackage

// File: rtl/stk_seq.sv
module stk_seq
   import stk_flag_pkg::*;
(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic [3:0]        op_in,
   output logic              busy,
   output logic [3:0]        cur_op,
   output logic [STEP_W-1:0] step,
   output logic              done
);
   logic              busy_r;
   logic [3:0]        op_r;
   logic [STEP_W-1:0] step_r;

   assign done   = busy_r && (step_r == last_step(op_r));
   assign busy   = busy_r;
   assign cur_op = op_r;
   assign step   = step_r;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         busy_r <= 1'b0;
         op_r   <= OPC_NOP;
         step_r <= '0;
      end else if (!busy_r) begin
         if (start) begin
            busy_r <= 1'b1;
            op_r   <= op_in;
            step_r <= '0;
         end
      end else if (done) begin
         busy_r <= 1'b0;
         step_r <= '0;
      end else begin
         step_r <= step_r + STEP_W'(1);
      end
   end
endmodule

// File: rtl/stk_ptr.sv
module stk_ptr #(
   parameter int          PTR_W    = 8,
   parameter logic [7:0]  PAGE     = 8'h01,
   parameter logic [7:0]  SP_RESET = 8'hFF,
   localparam int         ADDR_W   = PTR_W + 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              inc,
   input  logic              dec,
   output logic [PTR_W-1:0]  sp,
   output logic [ADDR_W-1:0] addr
);
   logic [PTR_W-1:0] sp_r;

   always_ff @(posedge clk) begin
      if (!rst_n)   sp_r <= PTR_W'(SP_RESET);
      else if (inc) sp_r <= sp_r + PTR_W'(1);
      else if (dec) sp_r <= sp_r - PTR_W'(1);
   end

   assign sp   = sp_r;
   assign addr = {PAGE, sp_r};
endmodule

// File: rtl/stk_regs.sv
module stk_regs #(
   parameter int         DATA_W  = 8,
   parameter logic [7:0] P_RESET = 8'h24
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                acc_ld,
   input  logic [DATA_W-1:0]   acc_d,
   input  logic                st_ld,
   input  logic [DATA_W-1:0]   st_d,
   input  logic [DATA_W-1:0]   st_set,
   input  logic [DATA_W-1:0]   st_clr,
   input  logic                pcl_ld,
   input  logic                pch_ld,
   input  logic [DATA_W-1:0]   pc_byte,
   output logic [DATA_W-1:0]   acc,
   output logic [DATA_W-1:0]   status,
   output logic [2*DATA_W-1:0] pc
);
   logic [DATA_W-1:0] acc_r, pcl_r, pch_r;
   logic [DATA_W-1:0] st_r;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         acc_r <= '0;
         pcl_r <= '0;
         pch_r <= '0;
      end else begin
         if (acc_ld) acc_r <= acc_d;
         if (pcl_ld) pcl_r <= pc_byte;
         if (pch_ld) pch_r <= pc_byte;
      end
   end

   // one flip-flop per status bit with its own load/set/clear priority
   for (genvar i = 0; i < DATA_W; i++) begin : g_flag
      always_ff @(posedge clk) begin
         if (!rst_n)         st_r[i] <= P_RESET[i];
         else if (st_ld)     st_r[i] <= st_d[i];
         else if (st_set[i]) st_r[i] <= 1'b1;
         else if (st_clr[i]) st_r[i] <= 1'b0;
      end
   end

   assign acc    = acc_r;
   assign status = st_r;
   assign pc     = {pch_r, pcl_r};
endmodule

// File: rtl/stk_flag_exec.sv
module stk_flag_exec
   import stk_flag_pkg::*;
#(
   parameter int         DATA_W     = 8,
   parameter logic [7:0] STACK_PAGE = 8'h01,
   parameter logic [7:0] SP_RESET   = 8'hFF,
   parameter logic [7:0] P_RESET    = 8'h24,
   localparam int        ADDR_W     = 2 * DATA_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic [3:0]        op_code,
   output logic [ADDR_W-1:0] mem_addr,
   output logic [DATA_W-1:0] mem_wdata,
   input  logic [DATA_W-1:0] mem_rdata,
   output logic              mem_we,
   output logic              mem_re,
   output logic              busy,
   output logic              done,
   output logic [DATA_W-1:0] acc_q,
   output logic [DATA_W-1:0] sp_q,
   output logic [DATA_W-1:0] status_q,
   output logic [ADDR_W-1:0] ret_pc
);
   if (DATA_W != 8) begin : g_bad_width
      $error("stk_flag_exec: DATA_W must be 8");
   end
   if (P_RESET[FL_B] || !P_RESET[FL_U]) begin : g_bad_reset
      $error("stk_flag_exec: P_RESET must have bit 5 set and bit 4 clear");
   end

   logic [3:0]        cur_op;
   logic [STEP_W-1:0] step;
   logic              sp_inc, sp_dec;
   logic              acc_ld, st_ld, pcl_ld, pch_ld;
   logic [DATA_W-1:0] st_d, st_set, st_clr;

   stk_seq u_seq (
      .clk    (clk),
      .rst_n  (rst_n),
      .start  (start),
      .op_in  (op_code),
      .busy   (busy),
      .cur_op (cur_op),
      .step   (step),
      .done   (done)
   );

   stk_ptr #(
      .PTR_W    (DATA_W),
      .PAGE     (STACK_PAGE),
      .SP_RESET (SP_RESET)
   ) u_ptr (
      .clk   (clk),
      .rst_n (rst_n),
      .inc   (sp_inc),
      .dec   (sp_dec),
      .sp    (sp_q),
      .addr  (mem_addr)
   );

   stk_regs #(
      .DATA_W  (DATA_W),
      .P_RESET (P_RESET)
   ) u_regs (
      .clk     (clk),
      .rst_n   (rst_n),
      .acc_ld  (acc_ld),
      .acc_d   (mem_rdata),
      .st_ld   (st_ld),
      .st_d    (st_d),
      .st_set  (st_set),
      .st_clr  (st_clr),
      .pcl_ld  (pcl_ld),
      .pch_ld  (pch_ld),
      .pc_byte (mem_rdata),
      .acc     (acc_q),
      .status  (status_q),
      .pc      (ret_pc)
   );

   assign mem_wdata = (cur_op == OPC_PHP) ? (status_q | STK_SPECIAL) : acc_q;

   // per-step control decode
   always_comb begin
      sp_inc = 1'b0;
      sp_dec = 1'b0;
      mem_we = 1'b0;
      mem_re = 1'b0;
      acc_ld = 1'b0;
      st_ld  = 1'b0;
      st_d   = status_q;
      st_set = '0;
      st_clr = '0;
      pcl_ld = 1'b0;
      pch_ld = 1'b0;
      if (busy) begin
         case (cur_op)
            OPC_CLC: st_clr[FL_C] = 1'b1;
            OPC_SEC: st_set[FL_C] = 1'b1;
            OPC_CLI: st_clr[FL_I] = 1'b1;
            OPC_SEI: st_set[FL_I] = 1'b1;
            OPC_CLV: st_clr[FL_V] = 1'b1;
            OPC_CLD: st_clr[FL_D] = 1'b1;
            OPC_SED: st_set[FL_D] = 1'b1;
            OPC_PHA, OPC_PHP: begin
               if (step == STEP_W'(0)) begin
                  mem_we = 1'b1;
                  sp_dec = 1'b1;
               end
            end
            OPC_PLA, OPC_PLP: begin
               if (step == STEP_W'(0)) sp_inc = 1'b1;
               if (step == STEP_W'(1)) mem_re = 1'b1;
               if (step == STEP_W'(2)) begin
                  st_ld = 1'b1;
                  if (cur_op == OPC_PLA) begin
                     acc_ld      = 1'b1;
                     st_d[FL_N]  = mem_rdata[DATA_W-1];
                     st_d[FL_Z]  = (mem_rdata == '0);
                  end else begin
                     st_d = mem_rdata & ~STK_SPECIAL;
                  end
               end
            end
            OPC_RTI: begin
               case (step)
                  STEP_W'(0): sp_inc = 1'b1;
                  STEP_W'(1): begin
                     mem_re = 1'b1;
                     sp_inc = 1'b1;
                  end
                  STEP_W'(2): begin
                     mem_re = 1'b1;
                     sp_inc = 1'b1;
                     st_ld  = 1'b1;
                     st_d   = mem_rdata & ~STK_SPECIAL;
                  end
                  STEP_W'(3): begin
                     mem_re = 1'b1;
                     pcl_ld = 1'b1;
                  end
                  STEP_W'(4): pch_ld = 1'b1;
                  default: ;
               endcase
            end
            default: ;
         endcase
      end
   end
endmodule

// File: rtl/stk_flag_chk.sv
module stk_flag_chk
   import stk_flag_pkg::*;
#(
   parameter logic [7:0] PAGE = 8'h01
) (
   input logic        clk,
   input logic        rst_n,
   input logic        busy,
   input logic        done,
   input logic [3:0]  cur_op,
   input logic        mem_we,
   input logic        mem_re,
   input logic [15:0] mem_addr,
   input logic [7:0]  mem_wdata,
   input logic [7:0]  sp_q,
   input logic [7:0]  acc_q,
   input logic [7:0]  status_q
);
   AST_STACK_PAGE: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_we || mem_re) |-> mem_addr[15:8] == PAGE); // R1

   AST_PUSH_DEC: assert property (@(posedge clk) disable iff (!rst_n)
      mem_we |=> sp_q == $past(sp_q) - 8'd1); // R2

   AST_RW_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
      !(mem_we && mem_re)); // R2

   AST_PHP_BITS: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_we && cur_op == OPC_PHP) |-> mem_wdata[5:4] == 2'b11); // R3

   AST_PULL_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
      (done && (cur_op == OPC_PLP || cur_op == OPC_RTI)) |=> status_q[5:4] == 2'b00); // R4

   AST_PLA_NZ: assert property (@(posedge clk) disable iff (!rst_n)
      (done && cur_op == OPC_PLA) |=> (status_q[7] == acc_q[7]) && (status_q[1] == (acc_q == 8'd0))); // R5

   AST_PLA_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
      (done && cur_op == OPC_PLA) |=> (status_q[6:2] == $past(status_q[6:2])) && (status_q[0] == $past(status_q[0]))); // R5

   AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> (!mem_we && !mem_re && !done)); // R8

   AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done); // R9

   AST_BUSY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && !done) |=> (busy && $stable(cur_op))); // R9
endmodule

bind stk_flag_exec stk_flag_chk #(.PAGE(STACK_PAGE)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .busy      (busy),
   .done      (done),
   .cur_op    (cur_op),
   .mem_we    (mem_we),
   .mem_re    (mem_re),
   .mem_addr  (mem_addr),
   .mem_wdata (mem_wdata),
   .sp_q      (sp_q),
   .acc_q     (acc_q),
   .status_q  (status_q)
);

// File: tb/stk_flag_exec_tb.sv
`timescale 1ns/1ps
module stk_flag_exec_tb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start = 1'b0;
   logic [3:0]  op_code = 4'd0;
   logic [15:0] mem_addr;
   logic [7:0]  mem_wdata;
   logic [7:0]  mem_rdata = 8'd0;
   logic        mem_we, mem_re, busy, done;
   logic [7:0]  acc_q, sp_q, status_q;
   logic [15:0] ret_pc;

   logic [7:0]  mem [256];
   logic        pre_we = 1'b0;
   logic [7:0]  pre_a = 8'd0, pre_d = 8'd0;
   logic        page_bad = 1'b0;

   int n_chk = 0;
   int n_bad = 0;
   logic [7:0]  m_sp, m_acc, m_p;
   logic [15:0] m_pc;

   always #4 clk = ~clk;

   stk_flag_exec u_dut (
      .clk(clk), .rst_n(rst_n), .start(start), .op_code(op_code),
      .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
      .mem_we(mem_we), .mem_re(mem_re), .busy(busy), .done(done),
      .acc_q(acc_q), .sp_q(sp_q), .status_q(status_q), .ret_pc(ret_pc)
   );

   always @(posedge clk) begin
      if (pre_we) mem[pre_a] <= pre_d;
      else if (mem_we) mem[mem_addr[7:0]] <= mem_wdata;
      if (mem_re) mem_rdata <= mem[mem_addr[7:0]];
   end

   always @(negedge clk)
      if (rst_n && (mem_we || mem_re) && mem_addr[15:8] != 8'h01) page_bad <= 1'b1;

   task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   task automatic poke(input logic [7:0] a, input logic [7:0] d);
      pre_we = 1'b1; pre_a = a; pre_d = d;
      @(negedge clk);
      pre_we = 1'b0;
   endtask

   task automatic state_chk(input string req);
      chk(req, "sp", {24'd0, sp_q}, {24'd0, m_sp});
      chk(req, "acc", {24'd0, acc_q}, {24'd0, m_acc});
      chk(req, "status", {24'd0, status_q}, {24'd0, m_p});
   endtask

   // R8: start at a negedge, count cycles to done, then R9 single pulse
   task automatic run(input logic [3:0] op, input int ncyc);
      int cnt;
      start = 1'b1; op_code = op;
      @(negedge clk);
      start = 1'b0;
      cnt = 1;
      while (!done && cnt < 16) begin
         @(negedge clk);
         cnt++;
      end
      chk("R8", "cycle count", cnt, ncyc);
      @(negedge clk);
      chk("R9", "done width", {31'd0, done}, 32'd0);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", n_chk + 1, n_bad + 1);
      $finish;
   end

   initial begin
      for (int i = 0; i < 256; i++) mem[i] = 8'd0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      m_sp = 8'hFF; m_acc = 8'h00; m_p = 8'h24; m_pc = 16'h0000;
      state_chk("R10");
      chk("R10", "ret_pc", {16'd0, ret_pc}, 32'd0);
      chk("R10", "busy/done", {30'd0, busy, done}, 32'd0);

      // R7 flag set/clear codes
      run(4'd2, 1); m_p[0] = 1'b1; state_chk("R7 SEC");
      run(4'd1, 1); m_p[0] = 1'b0; state_chk("R7 CLC");
      run(4'd3, 1); m_p[2] = 1'b0; state_chk("R7 CLI");
      run(4'd4, 1); m_p[2] = 1'b1; state_chk("R7 SEI");
      run(4'd7, 1); m_p[3] = 1'b1; state_chk("R7 SED");
      run(4'd6, 1); m_p[3] = 1'b0; state_chk("R7 CLD");
      run(4'd0, 1); state_chk("R8 NOP");

      // R5/R2: PLA over every byte, then PHA writes it back (wraps FF->00->FF)
      for (int v = 0; v < 256; v++) begin
         poke(m_sp + 8'd1, 8'(v));
         run(4'd9, 3);
         m_sp = m_sp + 8'd1;
         m_acc = 8'(v);
         m_p = (m_p & 8'h7D) | {m_acc[7], 5'd0, (m_acc == 8'd0), 1'b0};
         state_chk("R5 PLA");
         run(4'd8, 2);
         chk("R2 PHA", "stored", {24'd0, mem[m_sp]}, {24'd0, m_acc});
         m_sp = m_sp - 8'd1;
         chk("R2 PHA", "sp", {24'd0, sp_q}, {24'd0, m_sp});
      end

      // R4/R3: PLP over every byte, then PHP
      for (int v = 0; v < 256; v++) begin
         poke(m_sp + 8'd1, 8'(v));
         run(4'd11, 3);
         m_sp = m_sp + 8'd1;
         m_p = 8'(v) & 8'hCF;
         state_chk("R4 PLP");
         run(4'd10, 2);
         chk("R3 PHP", "stored", {24'd0, mem[m_sp]}, {24'd0, m_p | 8'h30});
         m_sp = m_sp - 8'd1;
      end
      run(4'd5, 1); m_p[6] = 1'b0; state_chk("R7 CLV");

      // R6: RTI, first one crossing the pointer wrap
      for (int k = 0; k < 4; k++) begin
         logic [7:0] sb, lo, hi;
         sb = 8'hF0 ^ 8'(k * 37);
         lo = 8'h34 + 8'(k);
         hi = 8'h12 ^ 8'(k << 4);
         poke(m_sp + 8'd1, sb);
         poke(m_sp + 8'd2, lo);
         poke(m_sp + 8'd3, hi);
         run(4'd12, 6);
         m_sp = m_sp + 8'd3;
         m_p = sb & 8'hCF;
         state_chk("R6 RTI");
         chk("R6", "ret_pc", {16'd0, ret_pc}, {16'd0, hi, lo});
      end

      // R11: unused codes
      for (int c = 13; c < 16; c++) begin
         run(4'(c), 1);
         state_chk("R11");
      end

      // R9: start held high across a whole PLA with a SEC code presented
      begin
         int cnt;
         logic [7:0] exp_p;
         exp_p = m_p;
         poke(m_sp + 8'd1, 8'h80);
         start = 1'b1; op_code = 4'd9;
         @(negedge clk);
         op_code = 4'd2;
         cnt = 1;
         while (!done && cnt < 16) begin
            @(negedge clk);
            cnt++;
         end
         start = 1'b0;
         chk("R9", "cycles with start held", cnt, 3);
         @(negedge clk);
         chk("R9", "done after", {31'd0, done}, 32'd0);
         chk("R9", "busy after", {31'd0, busy}, 32'd0);
         m_sp = m_sp + 8'd1;
         m_acc = 8'h80;
         m_p = (exp_p & 8'h7D) | 8'h80;
         state_chk("R9 ignored SEC");
      end

      chk("R1", "page violation seen", {31'd0, page_bad}, 32'd0);
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
   end
endmodule